// File: doc/BRIEF.md
# Runahead Mode Controller

This block keeps a small in-order core doing useful work while a long-latency load is outstanding. It holds the architectural register file, a shadow copy of it, and one poison flag per register. When a load that misses off-chip arrives in normal mode, the controller snapshots the register file and drops that load. It flags the load's destination as poisoned and switches to runahead.

In runahead, instructions keep executing. Any result that depends on a poisoned register is itself poisoned rather than written. Loads whose address register is clean raise a one-cycle prefetch request carrying the address value, so that further misses overlap with the first. When the first miss returns, the controller spends one busy cycle copying the snapshot back into the register file and clearing every poison flag. Normal execution then restarts, and the instruction source replays from the blocking load. A read port exposes each register's value and poison flag.

Top module: `runahead_ctrl`

## Requirements
- R1: After reset, and whenever reset is asserted, the block is in normal mode, not busy, with no prefetch, all registers zero and no register poisoned.
- R2: In normal mode, a valid instruction that is not a missing load writes in_data into in_dst, readable on the next cycle. The in_miss flag is ignored unless in_is_load is 1.
- R3: In normal mode, a valid load with in_miss=1 sets runahead on the next cycle. It leaves its destination value unchanged and poisons that destination.
- R4: The register file as it stood just before the blocking load is restored on return, so every register written in runahead reads back its old value.
- R5: In runahead, a non-load instruction whose source A or source B is poisoned poisons its destination and does not change its value.
- R6: In runahead, a non-load instruction with clean sources writes in_data into its destination and clears that destination's poison flag.
- R7: In runahead, a load whose address register (source A) is clean raises pf_valid for exactly one cycle, starting the cycle after issue, with pf_addr equal to that register's value. Its destination takes in_data if in_miss=0 and is poisoned if in_miss=1.
- R8: In runahead, a load whose address register is poisoned raises no prefetch and poisons its destination.
- R9: A miss_ret pulse in runahead makes busy high for exactly one cycle, with runahead low. Instructions offered during that cycle are ignored. Afterwards the block is in normal mode with every poison flag clear.
- R10: A miss_ret pulse in normal mode has no effect on the mode, busy, or any register value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | An instruction is offered this cycle |
| in_dst | input | AW | Destination register index |
| in_src_a | input | AW | Source A index (address register for loads) |
| in_src_b | input | AW | Source B index (unused for loads) |
| in_is_load | input | 1 | Instruction is a load |
| in_miss | input | 1 | Load misses off-chip |
| in_data | input | DW | Write-back value for the destination |
| miss_ret | input | 1 | Pulse: the blocking miss has returned |
| rd_addr | input | AW | Register read index |
| rd_data | output | DW | Value of register rd_addr |
| rd_poison | output | 1 | Poison flag of register rd_addr |
| runahead | output | 1 | Block is in runahead mode |
| busy | output | 1 | Checkpoint restore in progress |
| pf_valid | output | 1 | Prefetch request |
| pf_addr | output | DW | Prefetch address value |

## Verification
Every register write, poison change and mode change takes effect at the first rising edge after the instruction or pulse is offered. Prefetch is registered too, so pf_valid and pf_addr appear in the cycle after the load. After a return, busy shows one cycle later and restored values one cycle after that. The bench drives each step on a falling edge and samples on the next falling edge, once that single register stage has settled. It selects the read index only then, because the read port is combinational.

// File: rtl/runahead_ctrl.sv
module runahead_ctrl #(
  parameter int NREG = 8,
  parameter int DW = 8,
  localparam int AW = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [AW-1:0] in_dst,
  input  logic [AW-1:0] in_src_a,
  input  logic [AW-1:0] in_src_b,
  input  logic          in_is_load,
  input  logic          in_miss,
  input  logic [DW-1:0] in_data,
  input  logic          miss_ret,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          rd_poison,
  output logic          runahead,
  output logic          busy,
  output logic          pf_valid,
  output logic [DW-1:0] pf_addr
);
  typedef enum logic [1:0] {M_NORM, M_AHEAD, M_RESTORE} mode_t;

  mode_t            mode;
  logic [DW-1:0]    arf  [NREG];
  logic [DW-1:0]    ckpt [NREG];
  logic [NREG-1:0]  psn;

  wire in_run    = (mode == M_AHEAD);
  wire blk       = (mode == M_NORM) && in_valid && in_is_load && in_miss;
  wire src_bad   = psn[in_src_a] | (!in_is_load & psn[in_src_b]);
  wire ahead_psn = src_bad | (in_is_load & in_miss);
  wire pf_go     = in_run && in_valid && in_is_load && !psn[in_src_a];

  always_ff @(posedge clk) begin
    if (!rst_n) mode <= M_NORM;
    else begin
      case (mode)
        M_NORM:  if (blk) mode <= M_AHEAD;
        M_AHEAD: if (miss_ret) mode <= M_RESTORE;
        default: mode <= M_NORM;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) begin
        arf[i]  <= '0;
        ckpt[i] <= '0;
      end
      psn <= '0;
    end else begin
      case (mode)
        M_NORM: begin
          if (blk) begin
            for (int i = 0; i < NREG; i++) ckpt[i] <= arf[i];
            psn[in_dst] <= 1'b1;
          end else if (in_valid) begin
            arf[in_dst] <= in_data;
          end
        end
        M_AHEAD: begin
          if (in_valid) begin
            psn[in_dst] <= ahead_psn;
            if (!ahead_psn) arf[in_dst] <= in_data;
          end
        end
        default: begin
          for (int i = 0; i < NREG; i++) arf[i] <= ckpt[i];
          psn <= '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pf_valid <= 1'b0;
      pf_addr  <= '0;
    end else begin
      pf_valid <= pf_go;
      pf_addr  <= arf[in_src_a];
    end
  end

  assign runahead  = in_run;
  assign busy      = (mode == M_RESTORE);
  assign rd_data   = arf[rd_addr];
  assign rd_poison = psn[rd_addr];
endmodule

// File: rtl/runahead_chk.sv
module runahead_chk (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_is_load,
  input logic in_miss,
  input logic miss_ret,
  input logic runahead,
  input logic busy,
  input logic pf_valid,
  input logic rd_poison
);
  wire idle_norm = !runahead && !busy;
  wire blk_load  = in_valid && in_is_load && in_miss;

  AST_MISS_ENTERS: assert property (@(posedge clk) disable iff (!rst_n)
    idle_norm && blk_load |=> runahead); // R3
  AST_RESTORE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy && !runahead); // R9
  AST_RETURN_TO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    runahead && miss_ret |=> busy && !runahead); // R9
  AST_NORMAL_RETURN_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    idle_norm && miss_ret && !blk_load |=> !busy && !runahead); // R10
  AST_PREFETCH_FROM_AHEAD: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid |-> $past(runahead)); // R7
  AST_NORMAL_NO_POISON: assert property (@(posedge clk) disable iff (!rst_n)
    idle_norm |-> !rd_poison); // R9
  AST_MODES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(runahead && busy)); // R9
endmodule

bind runahead_ctrl runahead_chk i_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_is_load(in_is_load),
  .in_miss(in_miss), .miss_ret(miss_ret), .runahead(runahead), .busy(busy),
  .pf_valid(pf_valid), .rd_poison(rd_poison)
);

// File: tb/test_runahead_ctrl.sv
module test_runahead_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [2:0] in_dst = '0, in_src_a = '0, in_src_b = '0, rd_addr = '0;
  logic       in_is_load = 1'b0, in_miss = 1'b0, miss_ret = 1'b0;
  logic [7:0] in_data = '0;
  logic [7:0] rd_data, pf_addr;
  logic       rd_poison, runahead, busy, pf_valid;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  runahead_ctrl i_runahead_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dst(in_dst),
    .in_src_a(in_src_a), .in_src_b(in_src_b), .in_is_load(in_is_load),
    .in_miss(in_miss), .in_data(in_data), .miss_ret(miss_ret),
    .rd_addr(rd_addr), .rd_data(rd_data), .rd_poison(rd_poison),
    .runahead(runahead), .busy(busy), .pf_valid(pf_valid), .pf_addr(pf_addr)
  );

  typedef struct packed {
    logic       v;
    logic [2:0] d, a, b;
    logic       ld, ms, mr;
    logic [7:0] dat;
    logic [2:0] rr;
    logic       ra, bz, pf;
    logic [7:0] pa, rv;
    logic       rp;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t TBL [NV] = '{
    '{1'b1,3'd1,3'd0,3'd0,1'b0,1'b0,1'b0,8'h11, 3'd1,1'b0,1'b0,1'b0,8'h00,8'h11,1'b0,4'd2},  // R2 write r1
    '{1'b1,3'd2,3'd0,3'd0,1'b0,1'b0,1'b0,8'h22, 3'd2,1'b0,1'b0,1'b0,8'h00,8'h22,1'b0,4'd2},  // R2 write r2
    '{1'b1,3'd3,3'd1,3'd0,1'b1,1'b0,1'b0,8'h33, 3'd3,1'b0,1'b0,1'b0,8'h00,8'h33,1'b0,4'd2},  // R2 hit load
    '{1'b1,3'd4,3'd1,3'd0,1'b1,1'b1,1'b0,8'h44, 3'd4,1'b1,1'b0,1'b0,8'h00,8'h00,1'b1,4'd3},  // R3 blocking load
    '{1'b1,3'd5,3'd4,3'd2,1'b0,1'b0,1'b0,8'h55, 3'd5,1'b1,1'b0,1'b0,8'h00,8'h00,1'b1,4'd5},  // R5 via source A
    '{1'b1,3'd6,3'd2,3'd5,1'b0,1'b0,1'b0,8'h66, 3'd6,1'b1,1'b0,1'b0,8'h00,8'h00,1'b1,4'd5},  // R5 via source B
    '{1'b1,3'd1,3'd2,3'd3,1'b0,1'b0,1'b0,8'h99, 3'd1,1'b1,1'b0,1'b0,8'h00,8'h99,1'b0,4'd6},  // R6 clean write
    '{1'b1,3'd7,3'd1,3'd0,1'b1,1'b0,1'b0,8'h77, 3'd7,1'b1,1'b0,1'b1,8'h99,8'h77,1'b0,4'd7},  // R7 prefetch, hit
    '{1'b1,3'd2,3'd4,3'd0,1'b1,1'b1,1'b0,8'hEE, 3'd2,1'b1,1'b0,1'b0,8'h00,8'h22,1'b1,4'd8},  // R8 poisoned addr
    '{1'b1,3'd3,3'd7,3'd0,1'b1,1'b1,1'b0,8'hEE, 3'd3,1'b1,1'b0,1'b1,8'h77,8'h33,1'b1,4'd7},  // R7 prefetch, miss
    '{1'b0,3'd0,3'd0,3'd0,1'b0,1'b0,1'b1,8'h00, 3'd1,1'b0,1'b1,1'b0,8'h00,8'h99,1'b0,4'd9},  // R9 busy cycle
    '{1'b1,3'd0,3'd0,3'd0,1'b0,1'b0,1'b0,8'hAA, 3'd1,1'b0,1'b0,1'b0,8'h00,8'h11,1'b0,4'd4},  // R4 r1 restored
    '{1'b0,3'd0,3'd0,3'd0,1'b0,1'b0,1'b0,8'h00, 3'd0,1'b0,1'b0,1'b0,8'h00,8'h00,1'b0,4'd9},  // R9 busy write ignored
    '{1'b0,3'd0,3'd0,3'd0,1'b0,1'b0,1'b1,8'h00, 3'd2,1'b0,1'b0,1'b0,8'h00,8'h22,1'b0,4'd10}, // R10 stray return
    '{1'b1,3'd0,3'd0,3'd0,1'b0,1'b1,1'b0,8'h5A, 3'd0,1'b0,1'b0,1'b0,8'h00,8'h5A,1'b0,4'd2},  // R2 miss flag on ALU op
    '{1'b0,3'd0,3'd0,3'd0,1'b0,1'b0,1'b0,8'h00, 3'd7,1'b0,1'b0,1'b0,8'h00,8'h00,1'b0,4'd4},  // R4 r7 restored
    '{1'b0,3'd0,3'd0,3'd0,1'b0,1'b0,1'b0,8'h00, 3'd4,1'b0,1'b0,1'b0,8'h00,8'h00,1'b0,4'd4},  // R4 r4 clean
    '{1'b1,3'd4,3'd1,3'd0,1'b1,1'b0,1'b0,8'h44, 3'd4,1'b0,1'b0,1'b0,8'h00,8'h44,1'b0,4'd2}   // R2 replayed load hits
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    in_valid = 1'b0; in_is_load = 1'b0; in_miss = 1'b0; miss_ret = 1'b0;
  endtask

  initial begin
    #800000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 mode after reset", {29'd0, runahead, busy, pf_valid}, 32'd0);
    for (int r = 0; r < 8; r++) begin
      rd_addr = 3'(r);
      #1;
      check("R1 register clear after reset", {23'd0, rd_poison, rd_data}, 32'd0);
    end

    for (int i = 0; i < NV; i++) begin
      in_valid = TBL[i].v; in_dst = TBL[i].d; in_src_a = TBL[i].a; in_src_b = TBL[i].b;
      in_is_load = TBL[i].ld; in_miss = TBL[i].ms; miss_ret = TBL[i].mr; in_data = TBL[i].dat;
      @(negedge clk);
      rd_addr = TBL[i].rr;
      #1;
      checks++;
      if ({runahead, busy, pf_valid, pf_valid ? pf_addr : 8'h00, rd_data, rd_poison} !==
          {TBL[i].ra, TBL[i].bz, TBL[i].pf, TBL[i].pa, TBL[i].rv, TBL[i].rp}) begin
        fails++;
        $display("FAIL R%0d row %0d actual ra=%b bz=%b pf=%b pa=%h rv=%h rp=%b expected ra=%b bz=%b pf=%b pa=%h rv=%h rp=%b",
                 TBL[i].req, i, runahead, busy, pf_valid, pf_valid ? pf_addr : 8'h00, rd_data, rd_poison,
                 TBL[i].ra, TBL[i].bz, TBL[i].pf, TBL[i].pa, TBL[i].rv, TBL[i].rp);
      end
    end
    idle();

    // R7: prefetch lasts one cycle only
    @(negedge clk);
    check("R7 prefetch single cycle", {31'd0, pf_valid}, 32'd0);

    // R3 then R1: reset taken while running ahead
    in_valid = 1'b1; in_dst = 3'd6; in_src_a = 3'd1; in_is_load = 1'b1; in_miss = 1'b1;
    @(negedge clk);
    idle();
    rd_addr = 3'd6;
    #1;
    check("R3 enter before reset", {30'd0, runahead, rd_poison}, 32'd3);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    rd_addr = 3'd6;
    #1;
    check("R1 reset leaves runahead", {29'd0, runahead, busy, rd_poison}, 32'd0);
    rd_addr = 3'd4;
    #1;
    check("R1 reset clears registers", {24'd0, rd_data}, 32'd0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule